// File: doc/BRIEF.md
# Launch-Committed Descriptor Queue

This block holds outgoing message descriptors in a shared ring of 64 word registers. Software builds a descriptor by writing words into a staging window of 16 registers. The window is addressed relative to the current commit point (the tail). A single write of a length to the launch register then commits that many words in one step. Until that write, nothing staged is visible on the consumer side. Once a launch is accepted, the staging area begins again at offset 0, so software can start the next descriptor on the very next bus cycle.

A consumer port shows the oldest committed descriptor. It presents the descriptor's word count and any word selected by an index, and a pop advances the head past the whole descriptor, which frees its words. Software can read several status registers: room for the next descriptor, capped at the per-packet maximum; the staged length, which can also be written back so a context switch can restore it; and sticky error flags for a rejected launch length or a rejected restore length. Software can also read the head and tail pointers.

Top module: `desc_launch_queue`

## Requirements
- R1: After reset, head and tail read 0, the space register reads 16, the staged length reads 0, the error register reads 0 and the consumer valid output is low.
- R2: A bus write to address k in 0x00..0x0F stores the word in ring slot (tail+k) mod 64, and a read of that address returns it. The staged length (address 0x12) becomes the larger of its old value and k+1.
- R3: Staged words are not visible to the consumer: the consumer valid output stays low and the head and tail do not move until a launch is accepted.
- R4: A write of length L to address 0x10 is accepted when 1 <= L <= 16 and L <= space. From the next cycle the tail has advanced by L, the staged length reads 0, and the descriptor with length L and its words is offered to the consumer.
- R5: A launch length of 0, a length above 16, or a length above the space is rejected. Bit 0 of the error register (0x13) is set, and the tail and the staged length are unchanged.
- R6: The space register (0x11) reads min(64 - used words, 16), where used words is tail minus head.
- R7: A window write at an offset not below the space value is ignored: the slot contents and the staged length are unchanged.
- R8: A consumer pop while a descriptor is offered advances the head by its length. A pop with nothing offered has no effect.
- R9: The head and tail are 7-bit values (0x14, 0x15) whose low 6 bits index the ring and whose top bit is a wrap bit. A full ring (64 used, space 0) and an empty ring are both represented correctly across wraps.
- R10: A write to 0x12 with a value up to 16 restores the staged length. A larger value is ignored and sets bit 1 of the error register.
- R11: A write to 0x13 clears each error bit whose data bit is 1, and leaves the other error bits unchanged.
- R12: Descriptors reach the consumer in launch order, each with its own length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuWe | input | 1 | Bus write strobe |
| cpuAddr | input | 5 | Bus register address |
| cpuWdata | input | 32 | Bus write data |
| cpuRdata | output | 32 | Bus read data for cpuAddr (combinational) |
| conValid | output | 1 | A committed descriptor is offered |
| conLen | output | 5 | Word count of the offered descriptor |
| conIdx | input | 4 | Word index within the offered descriptor |
| conData | output | 32 | Word at conIdx of the offered descriptor |
| conPop | input | 1 | Release the offered descriptor |

## Verification
The bench fills the ring to exactly 64 words with four maximum launches. A design that confuses full with empty would then report 16 free words or drop the consumer valid output. A launch one word over the space must be refused, and a design that compares with the wrong bound would move the tail and overwrite unread data. The bench stages words, waits, and checks that the consumer still sees nothing. This catches a design that lets staged words leak before the launch. Random traffic crosses the 64-slot boundary many times. That exposes any pointer or window-offset arithmetic that fails to wrap, as well as a staged length that is not cleared on launch.

// File: rtl/dlq_pkg.sv
package dlq_pkg;
  localparam int ADDR_W = 5;
  localparam logic [ADDR_W-1:0] ADDR_LAUNCH = 5'h10;
  localparam logic [ADDR_W-1:0] ADDR_SPACE  = 5'h11;
  localparam logic [ADDR_W-1:0] ADDR_SAVE   = 5'h12;
  localparam logic [ADDR_W-1:0] ADDR_ERR    = 5'h13;
  localparam logic [ADDR_W-1:0] ADDR_HEAD   = 5'h14;
  localparam logic [ADDR_W-1:0] ADDR_TAIL   = 5'h15;

  // strobes issued by the control to the datapath
  typedef struct packed {
    logic stageWr;
    logic launch;
    logic pop;
  } dlq_strobe_t;
endpackage

// File: rtl/dlq_dpath.sv
module dlq_dpath
  import dlq_pkg::*;
#(
  parameter int DW      = 32,
  parameter int DEPTH   = 64,
  parameter int MAX_LEN = 16
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  dlq_strobe_t                    stb,
  input  logic [$clog2(MAX_LEN)-1:0]     winOff,
  input  logic [DW-1:0]                  stageData,
  input  logic [$clog2(MAX_LEN+1)-1:0]   launchLen,
  output logic [DW-1:0]                  winData,
  input  logic [$clog2(MAX_LEN)-1:0]     conIdx,
  output logic [DW-1:0]                  conData,
  output logic [$clog2(MAX_LEN+1)-1:0]   conLen,
  output logic                           conValid,
  output logic [$clog2(DEPTH):0]         usedWords,
  output logic [$clog2(DEPTH):0]         headPtr,
  output logic [$clog2(DEPTH):0]         tailPtr
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int LEN_W = $clog2(MAX_LEN + 1);

  logic [DW-1:0]    wordMem [DEPTH];
  logic [LEN_W-1:0] lenMem  [DEPTH];
  logic [PTR_W:0]   lqWr, lqRd;
  logic [PTR_W-1:0] winIdx, conSlot;
  logic [PTR_W:0]   descCount;

  assign winIdx    = tailPtr[PTR_W-1:0] + PTR_W'(winOff);
  assign conSlot   = headPtr[PTR_W-1:0] + PTR_W'(conIdx);
  assign winData   = wordMem[winIdx];
  assign conData   = wordMem[conSlot];
  assign conValid  = (lqWr != lqRd);
  assign conLen    = lenMem[lqRd[PTR_W-1:0]];
  assign usedWords = tailPtr - headPtr;
  assign descCount = lqWr - lqRd;

  always_ff @(posedge clk) begin
    if (stb.stageWr) wordMem[winIdx] <= stageData;
    if (stb.launch)  lenMem[lqWr[PTR_W-1:0]] <= launchLen;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tailPtr <= '0;
      headPtr <= '0;
      lqWr    <= '0;
      lqRd    <= '0;
    end else begin
      if (stb.launch) begin
        tailPtr <= tailPtr + (PTR_W+1)'(launchLen);
        lqWr    <= lqWr + 1'b1;
      end
      if (stb.pop) begin
        headPtr <= headPtr + (PTR_W+1)'(conLen);
        lqRd    <= lqRd + 1'b1;
      end
    end
  end

  // R9: the ring never holds more than DEPTH words
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    usedWords <= (PTR_W+1)'(DEPTH));
  // R4: a lone launch grows occupancy by exactly its length
  a_r4_launch_grows: assert property (@(posedge clk) disable iff (!rstN)
    (stb.launch && !stb.pop) |=> usedWords == $past(usedWords) + (PTR_W+1)'($past(launchLen)));
  // R8: a lone pop shrinks occupancy by the offered length
  a_r8_pop_shrinks: assert property (@(posedge clk) disable iff (!rstN)
    (stb.pop && !stb.launch) |=> usedWords == $past(usedWords) - (PTR_W+1)'($past(conLen)));
  // R12: every queued length covers at least one stored word
  a_r12_desc_count: assert property (@(posedge clk) disable iff (!rstN)
    descCount <= usedWords);
  a_r12_len_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    conValid |-> conLen != '0);
endmodule

// File: rtl/dlq_ctrl.sv
module dlq_ctrl
  import dlq_pkg::*;
#(
  parameter int DW      = 32,
  parameter int DEPTH   = 64,
  parameter int MAX_LEN = 16
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           cpuWe,
  input  logic [ADDR_W-1:0]              cpuAddr,
  input  logic [DW-1:0]                  cpuWdata,
  output logic [DW-1:0]                  cpuRdata,
  input  logic                           conPop,
  input  logic                           conValid,
  input  logic [$clog2(DEPTH):0]         usedWords,
  input  logic [$clog2(DEPTH):0]         headPtr,
  input  logic [$clog2(DEPTH):0]         tailPtr,
  input  logic [DW-1:0]                  winData,
  output dlq_strobe_t                    stb,
  output logic [$clog2(MAX_LEN)-1:0]     winOff,
  output logic [$clog2(MAX_LEN+1)-1:0]   launchLen
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int OFF_W = $clog2(MAX_LEN);
  localparam int LEN_W = $clog2(MAX_LEN + 1);

  logic [LEN_W-1:0] saveLen, spaceAvail, offPlusOne;
  logic [1:0]       errBits;
  logic [PTR_W:0]   freeWords;
  logic             isWin, launchOk, saveOk;

  assign freeWords  = (PTR_W+1)'(DEPTH) - usedWords;
  assign spaceAvail = (freeWords > (PTR_W+1)'(MAX_LEN)) ? LEN_W'(MAX_LEN)
                                                       : LEN_W'(freeWords);
  assign isWin      = (cpuAddr < ADDR_W'(MAX_LEN));
  assign winOff     = cpuAddr[OFF_W-1:0];
  assign offPlusOne = LEN_W'(winOff) + 1'b1;
  assign launchLen  = cpuWdata[LEN_W-1:0];
  assign launchOk   = (cpuWdata != '0) && (cpuWdata <= DW'(MAX_LEN))
                   && (cpuWdata <= DW'(spaceAvail));
  assign saveOk     = (cpuWdata <= DW'(MAX_LEN));

  always_comb begin
    stb.stageWr = cpuWe && isWin && (LEN_W'(winOff) < spaceAvail);
    stb.launch  = cpuWe && (cpuAddr == ADDR_LAUNCH) && launchOk;
    stb.pop     = conPop && conValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      saveLen <= '0;
      errBits <= '0;
    end else if (cpuWe) begin
      if (stb.stageWr && (offPlusOne > saveLen)) saveLen <= offPlusOne;
      if (cpuAddr == ADDR_LAUNCH) begin
        if (launchOk) saveLen <= '0;
        else          errBits[0] <= 1'b1;
      end
      if (cpuAddr == ADDR_SAVE) begin
        if (saveOk) saveLen <= cpuWdata[LEN_W-1:0];
        else        errBits[1] <= 1'b1;
      end
      if (cpuAddr == ADDR_ERR) errBits <= errBits & ~cpuWdata[1:0];
    end
  end

  always_comb begin
    cpuRdata = '0;
    if (isWin) cpuRdata = winData;
    else begin
      case (cpuAddr)
        ADDR_SPACE: cpuRdata = DW'(spaceAvail);
        ADDR_SAVE:  cpuRdata = DW'(saveLen);
        ADDR_ERR:   cpuRdata = DW'(errBits);
        ADDR_HEAD:  cpuRdata = DW'(headPtr);
        ADDR_TAIL:  cpuRdata = DW'(tailPtr);
        default:    cpuRdata = '0;
      endcase
    end
  end

  // R6: reported space never exceeds the per-packet cap
  a_r6_space_cap: assert property (@(posedge clk) disable iff (!rstN)
    spaceAvail <= LEN_W'(MAX_LEN));
  // R10: staged length stays within a legal descriptor size
  a_r10_save_bound: assert property (@(posedge clk) disable iff (!rstN)
    saveLen <= LEN_W'(MAX_LEN));
  // R4: an accepted launch restarts staging at zero
  a_r4_save_clears: assert property (@(posedge clk) disable iff (!rstN)
    stb.launch |=> saveLen == '0);
  // R5: a refused launch raises the error flag
  a_r5_reject_flags: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWe && cpuAddr == ADDR_LAUNCH && !stb.launch) |=> errBits[0]);
endmodule

// File: rtl/desc_launch_queue.sv
module desc_launch_queue
  import dlq_pkg::*;
#(
  parameter int DW      = 32,
  parameter int DEPTH   = 64,
  parameter int MAX_LEN = 16
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           cpuWe,
  input  logic [ADDR_W-1:0]              cpuAddr,
  input  logic [DW-1:0]                  cpuWdata,
  output logic [DW-1:0]                  cpuRdata,
  output logic                           conValid,
  output logic [$clog2(MAX_LEN+1)-1:0]   conLen,
  input  logic [$clog2(MAX_LEN)-1:0]     conIdx,
  output logic [DW-1:0]                  conData,
  input  logic                           conPop
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int OFF_W = $clog2(MAX_LEN);
  localparam int LEN_W = $clog2(MAX_LEN + 1);

  dlq_strobe_t      stb;
  logic [OFF_W-1:0] winOff;
  logic [LEN_W-1:0] launchLen;
  logic [DW-1:0]    winData;
  logic [PTR_W:0]   usedWords, headPtr, tailPtr;

  dlq_ctrl #(.DW(DW), .DEPTH(DEPTH), .MAX_LEN(MAX_LEN)) ctrl_i (
    .clk(clk), .rstN(rstN), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .conPop(conPop),
    .conValid(conValid), .usedWords(usedWords), .headPtr(headPtr),
    .tailPtr(tailPtr), .winData(winData), .stb(stb), .winOff(winOff),
    .launchLen(launchLen)
  );

  dlq_dpath #(.DW(DW), .DEPTH(DEPTH), .MAX_LEN(MAX_LEN)) dpath_i (
    .clk(clk), .rstN(rstN), .stb(stb), .winOff(winOff),
    .stageData(cpuWdata), .launchLen(launchLen), .winData(winData),
    .conIdx(conIdx), .conData(conData), .conLen(conLen),
    .conValid(conValid), .usedWords(usedWords), .headPtr(headPtr),
    .tailPtr(tailPtr)
  );
endmodule

// File: tb/desc_launch_queue_tb_top.sv
module desc_launch_queue_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuWe = 1'b0;
  logic [4:0]  cpuAddr = '0;
  logic [31:0] cpuWdata = '0;
  logic [31:0] cpuRdata;
  logic        conValid;
  logic [4:0]  conLen;
  logic [3:0]  conIdx = '0;
  logic [31:0] conData;
  logic        conPop = 1'b0;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  // bench model
  logic [31:0] mMem   [64];
  bit          mKnown [64];
  int          mHead = 0, mTail = 0, mSave = 0, mErr = 0;
  int          mLens[$];

  always #10 clk = ~clk;

  desc_launch_queue dut_i (
    .clk(clk), .rstN(rstN), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .conValid(conValid),
    .conLen(conLen), .conIdx(conIdx), .conData(conData), .conPop(conPop)
  );

  function automatic int mSpace();
    int f = 64 - (mTail - mHead);
    return (f > 16) ? 16 : f;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic busWr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    cpuWe = 1'b1; cpuAddr = a; cpuWdata = d;
    @(posedge clk);
    #1 cpuWe = 1'b0;
  endtask

  task automatic busRd(logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    cpuWe = 1'b0; cpuAddr = a;
    #2 d = cpuRdata;
  endtask

  task automatic stage(int k, logic [31:0] d);
    busWr(5'(k), d);
    if (k < mSpace()) begin
      mMem[(mTail + k) % 64] = d;
      mKnown[(mTail + k) % 64] = 1;
      if (k + 1 > mSave) mSave = k + 1;
    end
  endtask

  task automatic launch(int len);
    busWr(5'h10, 32'(len));
    if (len >= 1 && len <= 16 && len <= mSpace()) begin
      mLens.push_back(len); mTail += len; mSave = 0;
    end else mErr |= 1;
  endtask

  task automatic pop();
    @(negedge clk); conPop = 1'b1;
    @(posedge clk); #1 conPop = 1'b0;
    if (mLens.size() > 0) mHead += mLens.pop_front();
  endtask

  task automatic saveWr(int v);
    busWr(5'h12, 32'(v));
    if (v <= 16) mSave = v; else mErr |= 2;
  endtask

  task automatic errWr(int v);
    busWr(5'h13, 32'(v));
    mErr &= ~(v & 3);
  endtask

  task automatic checkStatus(string tag);
    logic [31:0] d;
    busRd(5'h11, d); check({tag, " R6 space"}, d, 32'(mSpace()));
    busRd(5'h12, d); check({tag, " R10 save"}, d, 32'(mSave));
    busRd(5'h13, d); check({tag, " R11 err"}, d, 32'(mErr));
    busRd(5'h14, d); check({tag, " R9 head"}, d, 32'(mHead % 128));
    busRd(5'h15, d); check({tag, " R9 tail"}, d, 32'(mTail % 128));
    check({tag, " R12 valid"}, 32'(conValid), 32'(mLens.size() > 0));
  endtask

  task automatic checkConsumer(string tag);
    if (mLens.size() > 0) begin
      check({tag, " R12 len"}, 32'(conLen), 32'(mLens[0]));
      for (int i = 0; i < mLens[0]; i++) begin
        if (mKnown[(mHead + i) % 64]) begin
          @(negedge clk); conIdx = 4'(i);
          #2 check({tag, " R4 data"}, conData, mMem[(mHead + i) % 64]);
        end
      end
    end
  endtask

  task automatic checkWindow(string tag);
    logic [31:0] d;
    for (int k = 0; k < 16; k++) begin
      if (mKnown[(mTail + k) % 64]) begin
        busRd(5'(k), d);
        check({tag, " R2 window"}, d, mMem[(mTail + k) % 64]);
      end
    end
  endtask

  initial begin
    #4000000;
    if (!done) begin
      nFails++; nChecks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int seed;
    seed = 1234;
    void'($urandom(seed));
    for (int i = 0; i < 64; i++) mKnown[i] = 0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset values
    checkStatus("R1 reset");

    // R3: staging is invisible
    stage(0, 32'hA0); stage(2, 32'hA2); stage(1, 32'hA1);
    repeat (3) @(posedge clk);
    check("R3 no valid while staging", 32'(conValid), 32'd0);
    busRd(5'h15, d); check("R3 tail still", d, 32'd0);
    busRd(5'h12, d); check("R2 save max", d, 32'd3);
    checkWindow("R2");
    // R4 launch, then stage next at once
    launch(3);
    stage(0, 32'hB0);
    check("R4 valid after launch", 32'(conValid), 32'd1);
    check("R4 len", 32'(conLen), 32'd3);
    checkConsumer("R4");
    checkStatus("R4");
    // R5 bad lengths
    launch(0); launch(17);
    checkStatus("R5 bad len");
    // R11 clear
    errWr(1);
    checkStatus("R11 clear");
    // R10 restore
    saveWr(20); saveWr(5);
    checkStatus("R10");
    errWr(3);
    pop();
    launch(5);
    pop();
    // R9 fill to full
    for (int p = 0; p < 4; p++) begin
      for (int k = 0; k < 16; k++) stage(k, 32'h1000 * (p + 1) + 32'(k));
      launch(16);
    end
    checkStatus("R9 full");
    busRd(5'h11, d); check("R9 full space zero", d, 32'd0);
    stage(0, 32'hDEAD);   // R7 ignored
    busRd(5'h12, d); check("R7 ignored save", d, 32'd0);
    launch(1);            // R5 over space
    checkStatus("R5 over space");
    pop();
    stage(15, 32'hBEEF);
    stage(0, 32'hCAFE);
    launch(16);           // exactly the freed space
    checkStatus("R9 refill");
    checkConsumer("R12 order");
    errWr(3);
    // R8 pop while empty
    while (mLens.size() > 0) pop();
    pop();
    checkStatus("R8 empty pop");

    // random traffic
    for (int it = 0; it < 1500; it++) begin
      int op = $urandom_range(0, 9);
      if (op <= 4) stage($urandom_range(0, 15), $urandom());
      else if (op == 5) launch(($urandom_range(0, 5) == 0) ? $urandom_range(0, 18) : (mSave > 0 ? mSave : 1));
      else if (op <= 7) pop();
      else if (op == 8) saveWr($urandom_range(0, 18));
      else errWr($urandom_range(0, 3));
      if (it % 10 == 0) begin
        checkStatus("rand");
        checkConsumer("rand");
        checkWindow("rand");
      end
    end
    checkStatus("final");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule